// File: doc/BRIEF.md
# Reversible Full-Period LFSR Address Generator

This block supplies the address stream for an on-chip memory self-test engine. It does not use a binary counter. The address register is a shift register with XOR feedback, so each step moves the bits one place and computes only a single new bit. This keeps toggling on the address lines low. A correction term built from the lower bits splices the all-zeros state into the cycle. The register therefore walks through every one of the 2^WIDTH addresses before it repeats.

The sequence can be walked in either direction. A direction select chooses between the forward feedback cone and its exact inverse, the reverse cone. Stepping downward therefore retraces the upward walk address by address. A start pulse loads the first address of the selected direction. A flag marks the last address of that direction. A sequencer can then run a march element from start to flag in either order and change direction between elements.

The step operation is decoded into four named operations:

- `OP_LOAD`: the start pulse is high. It takes priority over everything else.
- `OP_FWD`: the advance enable is high and the direction is ascending.
- `OP_REV`: the advance enable is high and the direction is descending.
- `OP_HOLD`: nothing is requested.

Top module: `lfsr_addr_gen`

## Requirements
- R1: While `rst_n` is low, `addr` is 0. Reset is asynchronous. After release the register keeps 0 until a step or start occurs.
- R2: On a clock edge with `start` high, `addr` loads 0 if `dir_down` is 0, or 2^(WIDTH-1) (only the MSB set, 0x80 at WIDTH 8) if `dir_down` is 1. `start` takes priority over `step_en`.
- R3: On an edge with `step_en` high, `start` low and `dir_down` 0, the next address is `{addr[WIDTH-2:0], fb}`. Here `fb` is the XOR of the tap bits, XORed with 1 when `addr[WIDTH-2:0]` is all zeros. At WIDTH 8 the taps are bits 7, 3, 2 and 1, so the sequence from 0 begins 0x00, 0x01, 0x02, 0x05, 0x0B, 0x16.
- R4: Starting at 0, ascending steps visit all 2^WIDTH addresses exactly once and then return to 0.
- R5: On an edge with `step_en` high, `start` low and `dir_down` 1, the next address is the unique address whose ascending successor is the current address.
- R6: With `start` and `step_en` both low, `addr` keeps its value whatever `dir_down` does.
- R7: `at_end` is high exactly when `addr` equals the terminal address of the current `dir_down`. The terminal address is 2^(WIDTH-1) when ascending and 0 when descending. The flag follows `dir_down` in the same cycle.
- R8: A step taken from the terminal address lands on the start address of that direction: from 0x80 ascending the next address is 0x00, and from 0x00 descending the next address is 0x80.
- R9: `dir_down` may change between any two steps. A reversal in the middle of a sweep retraces the addresses just visited.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_down | input | 1 | 0 selects the ascending walk, 1 selects the descending walk |
| step_en | input | 1 | Advance the address by one step this edge |
| start | input | 1 | Load the first address of the selected direction |
| addr | output | WIDTH | Current address |
| at_end | output | 1 | Current address is the terminal one for `dir_down` |

## Verification
Two pairs of functions can fall in the same cycle.

- A start pulse and an advance request. The stimulus table raises `start` and `step_en` on the same edge, under both directions. The bench then checks that the load address appears rather than a stepped one.
- The end flag and a step. The directed sweeps advance once more from the flagged terminal address. The bench judges that step by whether the address lands on that direction's start address.

The reversal cases check that a descending step undoes the preceding ascending step. The expected predecessor comes from a brute-force search over all addresses using the bench's own forward model.

// File: rtl/lfsr_addr_pkg.sv
package lfsr_addr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_FWD  = 2'd2,
        OP_REV  = 2'd3
    } step_op_e;

    // Tap masks of maximal-length shift-left registers. Bit k set means
    // state bit k joins the feedback XOR; the MSB is always a tap so the
    // step can be inverted.
    function automatic logic [7:0] tap_mask(input int unsigned width);
        logic [7:0] m;
        case (width)
            2:       m = 8'b0000_0011;
            3:       m = 8'b0000_0101;
            4:       m = 8'b0000_1001;
            5:       m = 8'b0001_0010;
            6:       m = 8'b0010_0001;
            7:       m = 8'b0100_0001;
            default: m = 8'b1000_1110;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lfsr_fwd_net.sv
module lfsr_fwd_net
    import lfsr_addr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [7:0]       TAPS8 = tap_mask(WIDTH);
    localparam logic [WIDTH-1:0] TAPS  = TAPS8[WIDTH-1:0];

    logic low_zero;
    logic fb;

    always_comb begin
        low_zero = ~|cur[WIDTH-2:0];
        fb       = (^(cur & TAPS)) ^ low_zero;
        nxt      = {cur[WIDTH-2:0], fb};
    end
endmodule

// File: rtl/lfsr_rev_net.sv
module lfsr_rev_net
    import lfsr_addr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prv
);
    localparam logic [7:0]       TAPS8 = tap_mask(WIDTH);
    localparam logic [WIDTH-2:0] LOW_TAPS = TAPS8[WIDTH-2:0];

    logic [WIDTH-2:0] low_bits;
    logic             old_msb;

    // The forward step shifted the old low bits up by one place; the
    // dropped MSB is recovered from the new bit 0 and the known taps.
    always_comb begin
        low_bits = cur[WIDTH-1:1];
        old_msb  = cur[0] ^ (^(low_bits & LOW_TAPS)) ^ (~|low_bits);
        prv      = {old_msb, low_bits};
    end
endmodule

// File: rtl/lfsr_end_detect.sv
module lfsr_end_detect #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] addr,
    input  logic             dir_down,
    output logic             at_end
);
    localparam logic [WIDTH-1:0] LAST_UP = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] LAST_DN = '0;

    always_comb begin
        if (dir_down) at_end = (addr == LAST_DN);
        else          at_end = (addr == LAST_UP);
    end
endmodule

// File: rtl/lfsr_addr_gen.sv
module lfsr_addr_gen
    import lfsr_addr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_down,
    input  logic             step_en,
    input  logic             start,
    output logic [WIDTH-1:0] addr,
    output logic             at_end
);
    localparam logic [WIDTH-1:0] FIRST_UP = '0;
    localparam logic [WIDTH-1:0] FIRST_DN = {1'b1, {(WIDTH-1){1'b0}}};

    step_op_e         op;
    logic [WIDTH-1:0] addr_q;
    logic [WIDTH-1:0] addr_d;
    logic [WIDTH-1:0] fwd_next;
    logic [WIDTH-1:0] rev_next;

    lfsr_fwd_net #(.WIDTH(WIDTH)) u_fwd (.cur(addr_q), .nxt(fwd_next));
    lfsr_rev_net #(.WIDTH(WIDTH)) u_rev (.cur(addr_q), .prv(rev_next));
    lfsr_end_detect #(.WIDTH(WIDTH)) u_end (
        .addr(addr_q), .dir_down(dir_down), .at_end(at_end)
    );

    // Operation select: load beats advance, advance beats hold.
    always_comb begin
        if (start)        op = OP_LOAD;
        else if (step_en) op = dir_down ? OP_REV : OP_FWD;
        else              op = OP_HOLD;
    end

    always_comb begin
        unique case (op)
            OP_LOAD: addr_d = dir_down ? FIRST_DN : FIRST_UP;
            OP_FWD:  addr_d = fwd_next;
            OP_REV:  addr_d = rev_next;
            default: addr_d = addr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;

    // Checker cone: undo the forward step with a second reverse network.
    logic [WIDTH-1:0] round_trip;
    lfsr_rev_net #(.WIDTH(WIDTH)) u_rev_chk (.cur(fwd_next), .prv(round_trip));

    // R5
    inverse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        round_trip == addr_q);

    // R2
    load_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !dir_down) |=> (addr == FIRST_UP));

    // R2
    load_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dir_down) |=> (addr == FIRST_DN));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !step_en) |=> $stable(addr));

    // R8
    wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && step_en && !dir_down && at_end) |=> (addr == FIRST_UP));

    // R8
    wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && step_en && dir_down && at_end) |=> (addr == FIRST_DN));

    // R4
    no_fixed_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && step_en) |=> (addr != $past(addr)));
endmodule

// File: tb/test_lfsr_addr_gen.sv
module test_lfsr_addr_gen;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dir_down = 1'b0;
    logic         step_en = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] addr;
    logic         at_end;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lfsr_addr_gen #(.WIDTH(W)) i_lfsr_addr_gen (
        .clk(clk), .rst_n(rst_n), .dir_down(dir_down),
        .step_en(step_en), .start(start), .addr(addr), .at_end(at_end)
    );

    // Row: start, dir_down, step_en, expected addr, expected at_end
    localparam int NV = 18;
    localparam logic [11:0] VEC [NV] = '{
        {3'b100, 8'h00, 1'b0},   // R2 load ascending
        {3'b001, 8'h01, 1'b0},   // R3
        {3'b001, 8'h02, 1'b0},   // R3
        {3'b000, 8'h02, 1'b0},   // R6
        {3'b001, 8'h05, 1'b0},   // R3
        {3'b001, 8'h0B, 1'b0},   // R3
        {3'b001, 8'h16, 1'b0},   // R3
        {3'b011, 8'h0B, 1'b0},   // R9 reverse mid-sweep
        {3'b011, 8'h05, 1'b0},   // R5
        {3'b010, 8'h05, 1'b0},   // R6 hold under descending
        {3'b001, 8'h0B, 1'b0},   // R9 forward again
        {3'b111, 8'h80, 1'b0},   // R2 start beats step, descending
        {3'b011, 8'h40, 1'b0},   // R5
        {3'b101, 8'h00, 1'b0},   // R2 start beats step, ascending
        {3'b011, 8'h80, 1'b0},   // R8 descending wrap from 0
        {3'b001, 8'h00, 1'b0},   // R8 ascending wrap from 0x80
        {3'b010, 8'h00, 1'b1},   // R7 terminal for descending
        {3'b000, 8'h00, 1'b0}    // R7 flag follows direction
    };

    // Bench model of the ascending step, from R3.
    function automatic logic [W-1:0] up_model(input logic [W-1:0] x);
        logic fb;
        fb = x[7] ^ x[3] ^ x[2] ^ x[1] ^ (x[6:0] == 7'd0);
        return {x[6:0], fb};
    endfunction

    // Predecessor by exhaustive search, from R5.
    function automatic logic [W-1:0] down_model(input logic [W-1:0] x);
        logic [W-1:0] r;
        r = '0;
        for (int k = 0; k < (1 << W); k++)
            if (up_model(W'(k)) == x) r = W'(k);
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic d, input logic e);
        start = s; dir_down = d; step_en = e;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] prev;
        bit seen [1 << W];

        repeat (3) @(negedge clk);
        check("R1 addr in reset", addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 addr after release", addr, 0);

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v][11], VEC[v][10], VEC[v][9]);
            check($sformatf("R3/R9 table row %0d addr", v), addr, VEC[v][8:1]);
            check($sformatf("R7 table row %0d at_end", v), at_end, VEC[v][0]);
        end

        // Full ascending sweep.
        drive(1'b1, 1'b0, 1'b0);
        check("R2 ascending start", addr, 0);
        for (int k = 0; k < (1 << W); k++) seen[k] = 1'b0;
        seen[0] = 1'b1;
        prev = addr;
        for (int i = 1; i < (1 << W); i++) begin
            drive(1'b0, 1'b0, 1'b1);
            check("R3 ascending step", addr, up_model(prev));
            check("R4 address not repeated", seen[addr], 0);
            check("R7 flag during ascent", at_end, (i == (1 << W) - 1));
            seen[addr] = 1'b1;
            prev = addr;
        end
        check("R7 ascending terminal", addr, 8'h80);
        drive(1'b0, 1'b0, 1'b1);
        check("R8 ascending wrap", addr, 0);

        // Full descending sweep.
        drive(1'b1, 1'b1, 1'b0);
        check("R2 descending start", addr, 8'h80);
        prev = addr;
        for (int i = 1; i < (1 << W); i++) begin
            drive(1'b0, 1'b1, 1'b1);
            check("R5 descending step", addr, down_model(prev));
            check("R7 flag during descent", at_end, (i == (1 << W) - 1));
            prev = addr;
        end
        check("R7 descending terminal", addr, 0);
        drive(1'b0, 1'b1, 1'b1);
        check("R8 descending wrap", addr, 8'h80);

        // Asynchronous reset in the middle of a sweep.
        drive(1'b0, 1'b1, 1'b1);
        #2 rst_n = 1'b0;
        #1 check("R1 async reset mid-sweep", addr, 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b0);
        check("R1 stays zero after release", addr, 0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule